// File: doc/BRIEF.md
# Synchronizer Mode Controller

This block decides how the phase-locked loop of a clock synchronizer is run. It picks the loop mode (Normal, Holdover or Freerun) and which of two timing references is in use, primary or secondary. Under manual control a two-bit mode field and a reference-select bit name the wanted state directly. Under automatic control the block moves between states on its own. It follows two loss-of-signal flags and a guard-time level, which usually comes back from an RC filter fed by the block's own guard-time output.

All control inputs are looked at only on the clock edge where the 8 kHz frame strobe is high, and every state change happens on that edge. A change of reference never goes straight from one Normal state to another. The block first spends a transitional holdover of `SWITCH_FRAMES` strobes, and during that time it raises a measure request so that the phase corrector can capture the offset of the new reference. It then enters Normal on the new reference with the corrector enabled. When the loop comes back from holdover to Normal on the same reference, the sampled guard time decides whether phase correction is applied.

Top module: `sync_mode_top`

## Requirements
- R1: `modeSel` selects the control: 2'b00 manual Normal, 2'b01 manual Holdover, 2'b10 manual Freerun, 2'b11 automatic. `loopMode` reports 2'b00 Normal, 2'b01 Holdover and 2'b10 Freerun.
- R2: Under manual control, `refSel`=0 selects the primary reference (`useSecondary`=0) and `refSel`=1 selects the secondary. Under automatic control `refSel` has no effect.
- R3: Inputs are sampled only on a rising clock edge with `frameTick` high. `loopMode`, `useSecondary`, `corrEnable`, `measurePulse` and `guardOut` change on no other edge.
- R4: `guardOut` holds the value `lossPri` had at the most recent frame strobe.
- R5: Under automatic control in Primary Normal, a strobe with `lossPri`=1 leads to Primary Holdover when `guardIn`=0, or when `guardIn`=1 and `lossSec`=1. When `guardIn`=1 and `lossSec`=0 it starts a switch to the secondary.
- R6: Leaving holdover for Normal on the same reference sets `corrEnable` to the `guardIn` sampled on that strobe, under both manual and automatic control.
- R7: `holdoverFlag` is high exactly when `loopMode` is Holdover, and this includes the transitional holdover.
- R8: A change of reference first gives `SWITCH_FRAMES` (default 1) strobes of holdover. During them `useSecondary` already shows the new reference and `measurePulse` is high. Normal on the new reference follows, with `corrEnable`=1. Inputs are ignored during the transitional holdover.
- R9: Under automatic control, Secondary Normal goes to Secondary Holdover when `lossSec`=1. Secondary Normal or Secondary Holdover starts a switch back to the primary when `lossPri`=0 and `guardIn`=1. Secondary Holdover whose secondary has returned otherwise goes back to Secondary Normal.
- R10: After reset, `loopMode`=Freerun and all other outputs are 0 until the first strobe. That strobe enters Primary Normal (automatic) or the manual state that has been selected, with `corrEnable`=0. Entering Normal from Freerun also clears `corrEnable`, and automatic control leaves Freerun for Primary Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameTick | input | 1 | 8 kHz frame strobe, one clock wide |
| modeSel | input | 2 | Control and mode select |
| refSel | input | 1 | Manual reference select |
| lossPri | input | 1 | Primary reference lost |
| lossSec | input | 1 | Secondary reference lost |
| guardIn | input | 1 | Guard-time level |
| useSecondary | output | 1 | Active reference is the secondary |
| loopMode | output | 2 | Loop mode: Normal, Holdover, Freerun |
| corrEnable | output | 1 | Phase-step corrector enable |
| holdoverFlag | output | 1 | Loop is in holdover |
| measurePulse | output | 1 | Corrector should measure the new reference's phase |
| guardOut | output | 1 | Primary loss flag captured on the strobe |

## Verification
A wrong internal state shows up at the ports one strobe after the decision that went wrong, as a wrong `loopMode`, a wrong `useSecondary` or a missing `measurePulse`. A wrong corrector choice shows only in `corrEnable`, and it stays visible until the next return to Normal. For this reason the bench compares every output after every strobe against a model built from the requirements. It also checks between strobes that nothing moves while the inputs are being scrambled. Automatic sequences that go through both holdover states and switch in both directions are driven directly, and long random runs mix automatic and manual control.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_NORM, ST_HOLD, ST_FREE, ST_SWITCH
  } ctlStateT;

  localparam logic [1:0] MS_NORMAL = 2'b00;
  localparam logic [1:0] MS_HOLD   = 2'b01;
  localparam logic [1:0] MS_FREE   = 2'b10;
  localparam logic [1:0] MS_AUTO   = 2'b11;

  localparam logic [1:0] LOOP_NORMAL = 2'b00;
  localparam logic [1:0] LOOP_HOLD   = 2'b01;
  localparam logic [1:0] LOOP_FREE   = 2'b10;

  typedef struct packed {
    logic corrSet;
    logic corrClr;
    logic corrFromGuard;
  } corrStrobeT;
endpackage

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int SWITCH_FRAMES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic [1:0] modeSel,
  input  logic       refSel,
  input  logic       lossPri,
  input  logic       lossSec,
  input  logic       guardIn,
  output ctlStateT   state,
  output logic       refSec,
  output corrStrobeT strobe
);
  localparam int CNT_W = (SWITCH_FRAMES < 2) ? 1 : $clog2(SWITCH_FRAMES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SWITCH_FRAMES - 1);

  ctlStateT        nState;
  logic            nSec;
  logic [CNT_W-1:0] swCnt, nCnt;
  corrStrobeT      sComb;
  logic            startSw, swTarget, isAuto;

  assign isAuto = (modeSel == MS_AUTO);

  always_comb begin
    nState   = state;
    nSec     = refSec;
    nCnt     = swCnt;
    sComb    = '0;
    startSw  = 1'b0;
    swTarget = refSec;
    if (state == ST_SWITCH) begin
      if (swCnt == '0) begin
        nState        = ST_NORM;
        sComb.corrSet = 1'b1;
      end else begin
        nCnt = swCnt - 1'b1;
      end
    end else if (state == ST_INIT) begin
      sComb.corrClr = 1'b1;
      if (isAuto) begin
        nState = ST_NORM;
        nSec   = 1'b0;
      end else begin
        nSec = refSel;
        case (modeSel)
          MS_NORMAL: nState = ST_NORM;
          MS_HOLD:   nState = ST_HOLD;
          default:   nState = ST_FREE;
        endcase
      end
    end else if (!isAuto) begin
      case (modeSel)
        MS_NORMAL: begin
          if (state == ST_FREE) begin
            nState        = ST_NORM;
            nSec          = refSel;
            sComb.corrClr = 1'b1;
          end else if (refSel != refSec) begin
            startSw  = 1'b1;
            swTarget = refSel;
          end else if (state == ST_HOLD) begin
            nState              = ST_NORM;
            sComb.corrFromGuard = 1'b1;
          end
        end
        MS_HOLD: begin
          nState = ST_HOLD;
          nSec   = refSel;
        end
        default: begin
          nState = ST_FREE;
          nSec   = refSel;
        end
      endcase
    end else begin
      case (state)
        ST_NORM: begin
          if (!refSec) begin
            if (lossPri) begin
              if (guardIn && !lossSec) begin
                startSw  = 1'b1;
                swTarget = 1'b1;
              end else begin
                nState = ST_HOLD;
              end
            end
          end else if (lossSec) begin
            nState = ST_HOLD;
          end else if (!lossPri && guardIn) begin
            startSw  = 1'b1;
            swTarget = 1'b0;
          end
        end
        ST_HOLD: begin
          if (!refSec) begin
            if (!lossPri) begin
              nState              = ST_NORM;
              sComb.corrFromGuard = 1'b1;
            end else if (guardIn && !lossSec) begin
              startSw  = 1'b1;
              swTarget = 1'b1;
            end
          end else if (!lossPri && guardIn) begin
            startSw  = 1'b1;
            swTarget = 1'b0;
          end else if (!lossSec) begin
            nState              = ST_NORM;
            sComb.corrFromGuard = 1'b1;
          end
        end
        default: begin
          nState        = ST_NORM;
          nSec          = 1'b0;
          sComb.corrClr = 1'b1;
        end
      endcase
    end
    if (startSw) begin
      nState = ST_SWITCH;
      nSec   = swTarget;
      nCnt   = CNT_LOAD;
    end
  end

  assign strobe = frameTick ? sComb : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_INIT;
      refSec <= 1'b0;
      swCnt  <= '0;
    end else if (frameTick) begin
      state  <= nState;
      refSec <= nSec;
      swCnt  <= nCnt;
    end
  end
endmodule

// File: rtl/sync_mode_dp.sv
module sync_mode_dp
  import sync_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       lossPri,
  input  logic       guardIn,
  input  ctlStateT   state,
  input  logic       refSec,
  input  corrStrobeT strobe,
  output logic       useSecondary,
  output logic [1:0] loopMode,
  output logic       corrEnable,
  output logic       holdoverFlag,
  output logic       measurePulse,
  output logic       guardOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrEnable <= 1'b0;
      guardOut   <= 1'b0;
    end else begin
      if (frameTick) guardOut <= lossPri;
      if (strobe.corrSet)            corrEnable <= 1'b1;
      else if (strobe.corrClr)       corrEnable <= 1'b0;
      else if (strobe.corrFromGuard) corrEnable <= guardIn;
    end
  end

  always_comb begin
    case (state)
      ST_NORM:            loopMode = LOOP_NORMAL;
      ST_HOLD, ST_SWITCH: loopMode = LOOP_HOLD;
      default:            loopMode = LOOP_FREE;
    endcase
  end

  assign useSecondary = refSec;
  assign holdoverFlag = (state == ST_HOLD) || (state == ST_SWITCH);
  assign measurePulse = (state == ST_SWITCH);
endmodule

// File: rtl/sync_mode_top.sv
module sync_mode_top
  import sync_mode_pkg::*;
#(
  parameter int SWITCH_FRAMES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic [1:0] modeSel,
  input  logic       refSel,
  input  logic       lossPri,
  input  logic       lossSec,
  input  logic       guardIn,
  output logic       useSecondary,
  output logic [1:0] loopMode,
  output logic       corrEnable,
  output logic       holdoverFlag,
  output logic       measurePulse,
  output logic       guardOut
);
  ctlStateT   state;
  logic       refSec;
  corrStrobeT strobe;

  sync_mode_ctrl #(.SWITCH_FRAMES(SWITCH_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .modeSel(modeSel),
    .refSel(refSel), .lossPri(lossPri), .lossSec(lossSec), .guardIn(guardIn),
    .state(state), .refSec(refSec), .strobe(strobe)
  );

  sync_mode_dp u_dp (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .lossPri(lossPri),
    .guardIn(guardIn), .state(state), .refSec(refSec), .strobe(strobe),
    .useSecondary(useSecondary), .loopMode(loopMode), .corrEnable(corrEnable),
    .holdoverFlag(holdoverFlag), .measurePulse(measurePulse), .guardOut(guardOut)
  );
endmodule

// File: rtl/sync_mode_checker.sv
module sync_mode_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameTick,
  input logic [1:0] modeSel,
  input logic       lossPri,
  input logic       guardIn,
  input logic       useSecondary,
  input logic [1:0] loopMode,
  input logic       corrEnable,
  input logic       holdoverFlag,
  input logic       measurePulse,
  input logic       guardOut
);
  assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(loopMode) && $stable(useSecondary) && $stable(corrEnable)
                   && $stable(measurePulse) && $stable(guardOut));

  assert_guard_echo_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> guardOut == $past(lossPri));

  assert_flag_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdoverFlag == (loopMode == 2'b01));

  assert_measure_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    measurePulse |-> holdoverFlag);

  assert_manual_free_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameTick && !measurePulse && modeSel == 2'b10 |=> loopMode == 2'b10);

  assert_auto_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameTick && modeSel == 2'b11 && loopMode == 2'b00 && !useSecondary
      && lossPri && !guardIn |=> loopMode == 2'b01 && !useSecondary);
endmodule

bind sync_mode_top sync_mode_checker u_checker (
  .clk(clk), .rstN(rstN), .frameTick(frameTick), .modeSel(modeSel),
  .lossPri(lossPri), .guardIn(guardIn), .useSecondary(useSecondary),
  .loopMode(loopMode), .corrEnable(corrEnable), .holdoverFlag(holdoverFlag),
  .measurePulse(measurePulse), .guardOut(guardOut)
);

// File: tb/tb_sync_mode_top.sv
module tb_sync_mode_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0;
  logic [1:0] modeSel = 2'b11;
  logic       refSel = 1'b0, lossPri = 1'b0, lossSec = 1'b0, guardIn = 1'b0;
  logic       useSecondary, corrEnable, holdoverFlag, measurePulse, guardOut;
  logic [1:0] loopMode;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state: mode 0 normal, 1 holdover, 2 freerun
  int mMode = 2;
  bit mSec = 0, mSw = 0, mCorr = 0, mGuard = 0, mInit = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_mode_top dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .modeSel(modeSel),
    .refSel(refSel), .lossPri(lossPri), .lossSec(lossSec), .guardIn(guardIn),
    .useSecondary(useSecondary), .loopMode(loopMode), .corrEnable(corrEnable),
    .holdoverFlag(holdoverFlag), .measurePulse(measurePulse), .guardOut(guardOut)
  );

  task automatic chk(input int act, input int exp, input string tag, input string ctx);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s): actual %0d expected %0d", tag, ctx, act, exp);
    end
  endtask

  task automatic startSwitch(input bit tgt);
    mSw = 1; mMode = 1; mSec = tgt;
  endtask

  task automatic modelStep(input bit [1:0] ms, input bit rs, input bit lp, input bit ls, input bit g);
    mGuard = lp;
    if (mInit) begin
      mInit = 0; mCorr = 0;
      if (ms == 3) begin mMode = 0; mSec = 0; end
      else begin mMode = ms; mSec = rs; end
    end else if (mSw) begin
      mSw = 0; mMode = 0; mCorr = 1;
    end else if (ms != 3) begin
      if (ms == 0) begin
        if (mMode == 2) begin mMode = 0; mSec = rs; mCorr = 0; end
        else if (rs != mSec) startSwitch(rs);
        else if (mMode == 1) begin mMode = 0; mCorr = g; end
      end else begin
        mMode = ms; mSec = rs;
      end
    end else if (mMode == 2) begin
      mMode = 0; mSec = 0; mCorr = 0;
    end else if (mMode == 0) begin
      if (!mSec) begin
        if (lp) begin
          if (g && !ls) startSwitch(1); else mMode = 1;
        end
      end else if (ls) mMode = 1;
      else if (!lp && g) startSwitch(0);
    end else begin
      if (!mSec) begin
        if (!lp) begin mMode = 0; mCorr = g; end
        else if (g && !ls) startSwitch(1);
      end else if (!lp && g) startSwitch(0);
      else if (!ls) begin mMode = 0; mCorr = g; end
    end
  endtask

  task automatic checkAll(input string ctx);
    chk(loopMode, mMode, "R1", ctx);
    chk(useSecondary, mSec, "R2", ctx);
    chk(guardOut, mGuard, "R4", ctx);
    chk(corrEnable, mCorr, "R6", ctx);
    chk(holdoverFlag, (mMode == 1), "R7", ctx);
    chk(measurePulse, mSw, "R8", ctx);
  endtask

  task automatic frame(input bit [1:0] ms, input bit rs, input bit lp, input bit ls,
                       input bit g, input int idle, input string ctx);
    @(negedge clk);
    modeSel = ms; refSel = rs; lossPri = lp; lossSec = ls; guardIn = g;
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
    modelStep(ms, rs, lp, ls, g);
    checkAll(ctx);
    for (int i = 0; i < idle; i++) begin
      modeSel = 2'($urandom); refSel = 1'($urandom);
      lossPri = 1'($urandom); lossSec = 1'($urandom); guardIn = 1'($urandom);
      @(negedge clk);
    end
    if (idle > 0) checkAll({"R3 between strobes, ", ctx});
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state before first strobe
    chk(loopMode, 2, "R10", "reset loop mode");
    chk(useSecondary, 0, "R10", "reset reference");
    chk(corrEnable, 0, "R10", "reset corrector");
    chk(holdoverFlag, 0, "R10", "reset holdover");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(loopMode, 2, "R10", "freerun until first strobe");

    // automatic sequences
    frame(3, 0, 0, 0, 0, 2, "R10 first strobe enters primary normal");
    frame(3, 1, 0, 0, 0, 1, "R2 refSel ignored in auto");
    frame(3, 0, 1, 0, 0, 1, "R5 guard low gives primary holdover");
    frame(3, 0, 0, 0, 1, 1, "R6 return with guard high enables corrector");
    frame(3, 0, 1, 0, 0, 0, "R5 second holdover");
    frame(3, 0, 0, 0, 0, 0, "R6 return with guard low disables corrector");
    frame(3, 0, 1, 1, 1, 0, "R5 both lost gives holdover");
    frame(3, 0, 1, 0, 1, 0, "R8 switch to secondary from holdover");
    frame(3, 0, 0, 1, 0, 2, "R8 transitional holdover ignores inputs");
    frame(3, 0, 1, 1, 0, 0, "R9 secondary lost gives secondary holdover");
    frame(3, 0, 1, 0, 0, 0, "R9 secondary back returns to secondary normal");
    frame(3, 0, 0, 0, 1, 0, "R9 primary back with guard high switches");
    frame(3, 0, 0, 0, 0, 0, "R8 normal on primary after switch");
    frame(3, 0, 1, 0, 1, 0, "R5 guard high switches to secondary");
    frame(3, 0, 1, 0, 1, 0, "R8 secondary normal after switch");

    // manual sequences
    frame(2, 0, 0, 0, 0, 0, "R1 manual freerun");
    frame(3, 1, 0, 0, 0, 0, "R10 auto leaves freerun for primary");
    frame(2, 1, 0, 0, 0, 0, "R1 manual freerun secondary");
    frame(0, 1, 0, 0, 1, 0, "R10 freerun to normal clears corrector");
    frame(0, 0, 0, 0, 0, 0, "R2 manual switch to primary");
    frame(0, 0, 0, 0, 0, 0, "R8 manual switch completes");
    frame(1, 0, 0, 0, 0, 0, "R1 manual holdover");
    frame(0, 0, 0, 0, 0, 0, "R6 manual return guard low");
    frame(1, 0, 0, 0, 0, 0, "R1 manual holdover again");
    frame(0, 0, 0, 0, 1, 0, "R6 manual return guard high");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit [1:0] ms;
      ms = ($urandom_range(0, 9) < 7) ? 2'b11 : 2'($urandom);
      frame(ms, 1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
            1'($urandom), $urandom_range(0, 3), "random R5 R9");
    end
    finishRun();
  end
endmodule